// File: doc/BRIEF.md
# Sensor Burst Program Sequencer

This block supplies a fixed program, one word at a time, to a small instruction-executing controller that sits next to a sensor. It replaces an instruction memory and a program counter with a dedicated state machine: the current state chooses the program word, a control bit that tells the controller whether the word opens a new instruction (1) or carries an immediate operand (0), and an instruction-valid flag. The sequencer moves to its next state only when the controller signals that it has taken the word on offer.

The program loads a start address into the controller's address register. It then offers the same burst-write instruction again and again. Each time the controller executes it, 8 data words are written starting at that register, and the register then grows by 8. The burst instruction is offered only while the sensor reports data ready, so the valid flag follows the sensor-valid input directly. After a parameterised number of accepted bursts (default 1024), the sequencer parks in a stall instruction with valid low and stays there until reset.

Every program word uses the same layout. Bits 31:24 hold the opcode and bits 23:16 hold the count of data words that follow the instruction; the remaining bits are zero. The opcodes, the burst length and the start address are parameters.

Top module: `sensorBurstSeq`

## Requirements
- R1: While reset is high and on the first cycle after it falls, the outputs are the address-load instruction: opcode SETOP_OPC (default 8'h10) in bits 31:24, count 1 in bits 23:16, zeros in bits 15:0, control bit 1, valid 1.
- R2: A word is accepted only in a cycle where instrRead and instrValid are both high. The address-load instruction is held until it is accepted, and is then followed by the address word.
- R3: The address word equals START_ADDR (default 32'h0000_4000), with control bit 0 and valid 1. Once accepted, it is followed by the burst instruction.
- R4: The burst instruction has opcode BURST_OPC (default 8'h24) in bits 31:24, the burst length BURST_WORDS (default 8) in bits 23:16, zeros below, and control bit 1. While it is offered, instrValid equals sensorValid in the same cycle.
- R5: In the burst state, an instrRead with sensorValid low has no effect. It is not counted and the burst instruction stays on offer.
- R6: Once exactly SAMPLE_LIMIT (default 1024) bursts have been accepted, the next cycle shows the stall word. Until then, the burst instruction remains on offer.
- R7: The stall word has opcode STALL_OPC (default 8'h0F), count 0, control bit 0 and valid 0. It persists whatever instrRead and sensorValid do, until reset.
- R8: A word that is on offer and not accepted keeps the same value and control bit in the next cycle.
- R9: Reset applied part-way through the bursts restarts the program at the address-load instruction and clears the burst count, so a full SAMPLE_LIMIT bursts are needed again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| instrRead | input | 1 | Controller takes the offered word this cycle |
| sensorValid | input | 1 | Sensor has a burst of data ready |
| progWord | output | 32 | Current program word |
| progCtl | output | 1 | 1 = instruction word, 0 = operand word |
| instrValid | output | 1 | Offered word may be taken |

## Verification
Two events can coincide in the same cycle: the last counted burst acceptance and the transition into the stall state. That cycle is also the one where the burst counter reaches its terminal value. Random read and sensor-valid patterns drive the sequencer through complete programs, so the final acceptance arrives with and without idle cycles and rejected reads around it. A cycle-accurate bench model is compared with all three outputs on every cycle. The model is judged correct only if exactly SAMPLE_LIMIT bursts come before the stall word. A reset that lands in mid-burst tests the same counter from a cleared start.

// File: rtl/sbs_pkg.sv
package sbs_pkg;

  // program position held by the control state machine
  typedef enum logic [1:0] {
    PH_SETOP = 2'd0,
    PH_ADDR  = 2'd1,
    PH_BURST = 2'd2,
    PH_DONE  = 2'd3
  } phase_e;

  // strobes from control to datapath
  typedef struct packed {
    phase_e phase;
    logic   cntClr;
    logic   cntInc;
  } seqStrobe_t;

  localparam int OPC_W = 8;
  localparam int LEN_W = 8;

endpackage

// File: rtl/sbs_ctrl.sv
module sbs_ctrl
  import sbs_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       instrRead,
  input  logic       instrValid,
  input  logic       lastSample,
  output seqStrobe_t strobe
);

  phase_e phase;
  phase_e phaseNext;
  logic   accept;

  assign accept = instrRead & instrValid;

  always_comb begin
    phaseNext = phase;
    unique case (phase)
      PH_SETOP: if (accept) phaseNext = PH_ADDR;
      PH_ADDR:  if (accept) phaseNext = PH_BURST;
      PH_BURST: if (accept && lastSample) phaseNext = PH_DONE;
      PH_DONE:  phaseNext = PH_DONE;
      default:  phaseNext = PH_SETOP;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) phase <= PH_SETOP;
    else     phase <= phaseNext;
  end

  always_comb begin
    strobe.phase  = phase;
    strobe.cntClr = (phase == PH_SETOP);
    strobe.cntInc = (phase == PH_BURST) && accept;
  end

endmodule

// File: rtl/sbs_datapath.sv
module sbs_datapath
  import sbs_pkg::*;
#(
  parameter int              WORD_W       = 32,
  parameter int              SAMPLE_LIMIT = 1024,
  parameter int              BURST_WORDS  = 8,
  parameter logic [WORD_W-1:0] START_ADDR = 32'h0000_4000,
  parameter logic [OPC_W-1:0]  SETOP_OPC  = 8'h10,
  parameter logic [OPC_W-1:0]  BURST_OPC  = 8'h24,
  parameter logic [OPC_W-1:0]  STALL_OPC  = 8'h0F
) (
  input  logic              clk,
  input  logic              rst,
  input  seqStrobe_t        strobe,
  input  logic              sensorValid,
  output logic [WORD_W-1:0] progWord,
  output logic              progCtl,
  output logic              instrValid,
  output logic              lastSample
);

  localparam int CNT_W = $clog2(SAMPLE_LIMIT + 1);
  localparam int PAD_W = WORD_W - OPC_W - LEN_W;
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(SAMPLE_LIMIT - 1);

  localparam logic [WORD_W-1:0] SETOP_WORD = {SETOP_OPC, LEN_W'(1), {PAD_W{1'b0}}};
  localparam logic [WORD_W-1:0] BURST_WORD = {BURST_OPC, LEN_W'(BURST_WORDS), {PAD_W{1'b0}}};
  localparam logic [WORD_W-1:0] STALL_WORD = {STALL_OPC, LEN_W'(0), {PAD_W{1'b0}}};

  logic [CNT_W-1:0] sampleCnt;

  always_ff @(posedge clk) begin
    if (rst || strobe.cntClr) sampleCnt <= '0;
    else if (strobe.cntInc)   sampleCnt <= sampleCnt + 1'b1;
  end

  assign lastSample = (sampleCnt == LAST_CNT);

  always_comb begin
    progWord   = STALL_WORD;
    progCtl    = 1'b0;
    instrValid = 1'b0;
    unique case (strobe.phase)
      PH_SETOP: begin progWord = SETOP_WORD; progCtl = 1'b1; instrValid = 1'b1;        end
      PH_ADDR:  begin progWord = START_ADDR; progCtl = 1'b0; instrValid = 1'b1;        end
      PH_BURST: begin progWord = BURST_WORD; progCtl = 1'b1; instrValid = sensorValid; end
      PH_DONE:  begin progWord = STALL_WORD; progCtl = 1'b0; instrValid = 1'b0;        end
      default:  begin progWord = STALL_WORD; progCtl = 1'b0; instrValid = 1'b0;        end
    endcase
  end

endmodule

// File: rtl/sensorBurstSeq.sv
module sensorBurstSeq #(
  parameter int          WORD_W       = 32,
  parameter int          SAMPLE_LIMIT = 1024,
  parameter int          BURST_WORDS  = 8,
  parameter logic [31:0] START_ADDR   = 32'h0000_4000,
  parameter logic [7:0]  SETOP_OPC    = 8'h10,
  parameter logic [7:0]  BURST_OPC    = 8'h24,
  parameter logic [7:0]  STALL_OPC    = 8'h0F
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              instrRead,
  input  logic              sensorValid,
  output logic [WORD_W-1:0] progWord,
  output logic              progCtl,
  output logic              instrValid
);

  sbs_pkg::seqStrobe_t strobe;
  logic lastSample;

  sbs_ctrl u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .instrRead  (instrRead),
    .instrValid (instrValid),
    .lastSample (lastSample),
    .strobe     (strobe)
  );

  sbs_datapath #(
    .WORD_W       (WORD_W),
    .SAMPLE_LIMIT (SAMPLE_LIMIT),
    .BURST_WORDS  (BURST_WORDS),
    .START_ADDR   (WORD_W'(START_ADDR)),
    .SETOP_OPC    (SETOP_OPC),
    .BURST_OPC    (BURST_OPC),
    .STALL_OPC    (STALL_OPC)
  ) u_dp (
    .clk         (clk),
    .rst         (rst),
    .strobe      (strobe),
    .sensorValid (sensorValid),
    .progWord    (progWord),
    .progCtl     (progCtl),
    .instrValid  (instrValid),
    .lastSample  (lastSample)
  );

endmodule

// File: rtl/sensorBurstSeq_chk.sv
module sensorBurstSeq_chk #(
  parameter int          WORD_W       = 32,
  parameter int          SAMPLE_LIMIT = 1024,
  parameter int          BURST_WORDS  = 8,
  parameter logic [31:0] START_ADDR   = 32'h0000_4000,
  parameter logic [7:0]  SETOP_OPC    = 8'h10,
  parameter logic [7:0]  BURST_OPC    = 8'h24,
  parameter logic [7:0]  STALL_OPC    = 8'h0F
) (
  input logic              clk,
  input logic              rst,
  input logic              instrRead,
  input logic              sensorValid,
  input logic [WORD_W-1:0] progWord,
  input logic              progCtl,
  input logic              instrValid
);

  localparam int CNT_W = $clog2(SAMPLE_LIMIT + 1);
  localparam logic [WORD_W-1:0] W_SETOP = {SETOP_OPC, 8'd1, {(WORD_W-16){1'b0}}};
  localparam logic [WORD_W-1:0] W_BURST = {BURST_OPC, 8'(BURST_WORDS), {(WORD_W-16){1'b0}}};
  localparam logic [WORD_W-1:0] W_STALL = {STALL_OPC, 8'd0, {(WORD_W-16){1'b0}}};

  logic [CNT_W-1:0] seenBursts;
  logic burstTaken;

  assign burstTaken = (progWord == W_BURST) && progCtl && instrValid && instrRead;

  always_ff @(posedge clk) begin
    if (rst)             seenBursts <= '0;
    else if (burstTaken) seenBursts <= seenBursts + 1'b1;
  end

  p_reset_start_r1: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (progWord == W_SETOP && progCtl && instrValid));

  p_burst_valid_r4: assert property (@(posedge clk) disable iff (rst)
    (progWord == W_BURST && progCtl) |-> (instrValid == sensorValid));

  p_addr_follows_r3: assert property (@(posedge clk) disable iff (rst)
    (progWord == W_SETOP && progCtl && instrRead) |=>
      (progWord == WORD_W'(START_ADDR) && !progCtl && instrValid));

  p_limit_stall_r6: assert property (@(posedge clk) disable iff (rst)
    (burstTaken && seenBursts == CNT_W'(SAMPLE_LIMIT - 1)) |=> (progWord == W_STALL));

  p_limit_early_r6: assert property (@(posedge clk) disable iff (rst)
    (burstTaken && seenBursts < CNT_W'(SAMPLE_LIMIT - 1)) |=> (progWord == W_BURST));

  p_done_sticky_r7: assert property (@(posedge clk) disable iff (rst)
    (progWord == W_STALL && !progCtl) |=> (progWord == W_STALL && !progCtl && !instrValid));

  p_hold_word_r8: assert property (@(posedge clk) disable iff (rst)
    (instrValid && !instrRead) |=> ($stable(progWord) && $stable(progCtl)));

endmodule

bind sensorBurstSeq sensorBurstSeq_chk #(
  .WORD_W       (WORD_W),
  .SAMPLE_LIMIT (SAMPLE_LIMIT),
  .BURST_WORDS  (BURST_WORDS),
  .START_ADDR   (START_ADDR),
  .SETOP_OPC    (SETOP_OPC),
  .BURST_OPC    (BURST_OPC),
  .STALL_OPC    (STALL_OPC)
) u_chk (
  .clk         (clk),
  .rst         (rst),
  .instrRead   (instrRead),
  .sensorValid (sensorValid),
  .progWord    (progWord),
  .progCtl     (progCtl),
  .instrValid  (instrValid)
);

// File: tb/sensorBurstSeq_tb.sv
module sensorBurstSeq_tb;

  localparam int LIMIT = 1024;
  localparam logic [31:0] E_SETOP = 32'h1001_0000;
  localparam logic [31:0] E_ADDR  = 32'h0000_4000;
  localparam logic [31:0] E_BURST = 32'h2408_0000;
  localparam logic [31:0] E_STALL = 32'h0F00_0000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        instrRead = 1'b0;
  logic        sensorValid = 1'b0;
  logic [31:0] progWord;
  logic        progCtl;
  logic        instrValid;

  int vecCount = 0;
  int failCount = 0;
  int mPhase = 0;   // 0 setop, 1 addr, 2 burst, 3 done
  int mCnt = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  sensorBurstSeq u_dut (
    .clk(clk), .rst(rst), .instrRead(instrRead), .sensorValid(sensorValid),
    .progWord(progWord), .progCtl(progCtl), .instrValid(instrValid)
  );

  function automatic logic [31:0] expWord(int ph);
    case (ph)
      0: return E_SETOP;
      1: return E_ADDR;
      2: return E_BURST;
      default: return E_STALL;
    endcase
  endfunction

  function automatic logic expCtl(int ph);
    return (ph == 0) || (ph == 2);
  endfunction

  function automatic logic expValid(int ph, logic sv);
    if (ph == 2) return sv;
    return (ph == 0) || (ph == 1);
  endfunction

  function automatic string reqOf(int ph);
    case (ph)
      0: return "R1/R2";
      1: return "R3";
      2: return "R4/R5";
      default: return "R7";
    endcase
  endfunction

  task automatic checkNow(string req);
    logic [31:0] w = expWord(mPhase);
    logic c = expCtl(mPhase);
    logic v = expValid(mPhase, sensorValid);
    vecCount++;
    if (progWord !== w || progCtl !== c || instrValid !== v) begin
      failCount++;
      $display("FAIL %s: word=%h ctl=%b valid=%b expected word=%h ctl=%b valid=%b",
               req, progWord, progCtl, instrValid, w, c, v);
    end
  endtask

  // drive one cycle, check outputs, then advance the model to the next edge
  task automatic step(logic rd, logic sv, logic rs, string req);
    @(negedge clk);
    instrRead = rd; sensorValid = sv; rst = rs;
    #1;
    checkNow(req);
    if (rs) begin
      mPhase = 0; mCnt = 0;
    end else if (rd && expValid(mPhase, sv)) begin
      case (mPhase)
        0: mPhase = 1;
        1: mPhase = 2;
        2: begin mCnt++; if (mCnt == LIMIT) mPhase = 3; end
        default: ;
      endcase
    end
  endtask

  task automatic runRandom(int rdPct, int svPct, int stopCnt);
    while (mPhase != 3 && !(stopCnt >= 0 && mCnt >= stopCnt))
      step(($urandom % 100) < rdPct, ($urandom % 100) < svPct, 1'b0, reqOf(mPhase));
  endtask

  initial begin
    void'($urandom(32'h5EED_1234));
    // reset state, R1
    step(1'b1, 1'b1, 1'b1, "R1");
    step(1'b0, 1'b0, 1'b1, "R1");
    // hold on offer without read, R2 and R8
    step(1'b0, 1'b0, 1'b0, "R1");
    step(1'b0, 1'b1, 1'b0, "R2 R8");
    step(1'b1, 1'b0, 1'b0, "R2");
    step(1'b0, 1'b0, 1'b0, "R3 R8");
    step(1'b1, 1'b0, 1'b0, "R3");
    // burst: reads while sensor not ready are ignored, R5
    for (int i = 0; i < 6; i++) step(1'b1, 1'b0, 1'b0, "R5");
    step(1'b0, 1'b1, 1'b0, "R4 R8");
    step(1'b1, 1'b1, 1'b0, "R4");
    // random run until a mid-program reset, R9
    runRandom(60, 50, 300);
    step(1'b1, 1'b1, 1'b1, "R9");
    step(1'b0, 1'b1, 1'b0, "R9");
    // full program after reset, busy pattern
    runRandom(80, 70, -1);
    // stall state ignores everything, R6 R7
    if (mCnt != LIMIT) begin
      failCount++;
      $display("FAIL R6: bursts=%0d expected=%0d", mCnt, LIMIT);
    end
    vecCount++;
    for (int i = 0; i < 12; i++) step(i[0], i[1], 1'b0, "R6 R7");
    // another full program with sparse handshakes
    step(1'b0, 1'b0, 1'b1, "R9");
    runRandom(35, 40, -1);
    for (int i = 0; i < 4; i++) step(1'b1, 1'b1, 1'b0, "R7");
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vecCount, failCount);
    $finish;
  end

  initial begin
    #1_500_000;
    if (!finished) begin
      failCount++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vecCount, failCount);
      $finish;
    end
  end

endmodule